// File: doc/BRIEF.md
# Pulse-Width Measurement Timer

This block measures how long a pulse input stays high. It counts in units of an external count tick. Software controls it through one byte-wide control and status register. Writing a one to the start command arms the timer and clears the counter. The next rising edge of the synchronised pulse input begins a measurement, and the falling edge after it ends the measurement. At the end, the count is copied into a 16-bit result register, the done flag is raised and the timer returns to idle. The stop command abandons any armed or running measurement.

The counter is 16 bits wide and advances only on cycles where the tick input is high during a measurement. When it wraps from 0xFFFF to 0x0000, the block raises an overflow flag and inverts a pulse output pin. The done flag and the overflow flag each have an enable bit, and each drives its own interrupt line. An error flag records that a new result replaced one that software had not yet consumed. A one-cycle result read strobe consumes the result.

The controller is a three-state machine: IDLE (not counting), ARMED (waiting for a rising edge) and MEASURE (counting ticks). It has four named transitions. T_START goes from any state to ARMED on a start command. T_STOP goes from any state to IDLE on a stop command, and it wins over T_START. T_BEGIN goes from ARMED to MEASURE on a rising edge. T_DONE goes from MEASURE to IDLE on a falling edge.

Top module: `pulse_width_timer`

## Requirements
- R1: After reset, every register bit reads 0, the result is 0, and both interrupt lines and the pulse output are 0.
- R2: A register write with bit 7 set (start) and bit 6 clear leads, one cycle later, to bits 7:6 reading 11, the done flag (bit 5) reading 0 and the counter at zero. A write with bit 7 clear issues no start, and bits 7:6 only ever read 00 or 11.
- R3: A register write with bit 6 set (stop) leads, one cycle later, to bits 7:6 reading 00 with no result captured. This holds even when bit 7 is set in the same write.
- R4: While ARMED, a rising edge of the pulse input starts counting, seen three clock cycles after the pin changes because of a two-flop synchroniser and an edge register. The following falling edge copies the count into `result`, sets the done flag and returns bits 7:6 to 00.
- R5: The done flag (bit 5) reads 0 from a start until the measurement ends, and then reads 1 until the next start.
- R6: The overflow flag (bit 3) sets on the counter wrap from 0xFFFF to 0x0000. A write with bit 3 clear clears it, and a write with bit 3 set leaves it unchanged. A wrap in the same cycle as a clearing write leaves it set.
- R7: The pulse output, which is also readable as bit 0, inverts on every counter wrap and at no other time.
- R8: `irq_done` is 1 exactly while the done flag and its enable (bit 4) are both 1. `irq_ovf` is 1 exactly while the overflow flag and its enable (bit 2) are both 1.
- R9: The error flag (bit 1) sets when a result is captured while the previous result is still unconsumed. A `res_rd` pulse clears it and marks the result consumed. A capture in the same cycle keeps it set.
- R10: Bits 4 and 2 are read/write enables. Writes have no effect on bits 5, 1 and 0.
- R11: The counter advances only on tick cycles in MEASURE. Ticks in IDLE or ARMED, ticks in the ending cycle, and pulse edges while IDLE have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read-back value |
| pulse_in | input | 1 | Asynchronous pulse to be measured |
| tick | input | 1 | Count enable from the prescaler |
| res_rd | input | 1 | Result consumed strobe |
| result | output | 16 | Last captured pulse width |
| irq_done | output | 1 | Measurement-done interrupt |
| irq_ovf | output | 1 | Counter-overflow interrupt |
| pulse_out | output | 1 | Output toggled on each counter wrap |

## Verification
The bound assertions check, on every cycle, the local rules of the block. The run code must always read 00 or 11. A start must arm and a stop must idle one cycle after the write. The overflow flag must be sticky and set by each wrap. The pulse output must change exactly on a wrap. Each interrupt must be backed by its flag, and the error flag may rise only on a capture. Only the bench's scenarios can show the values that depend on history: the exact result captured after synchroniser latency with sparse ticks, overwrite detection across back-to-back measurements, restart and stop in the middle of a pulse, and the wrap coinciding with a clearing write after 65,535 ticks.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_MEASURE = 2'd2
    } pwt_state_e;

    localparam int unsigned CSR_W    = 8;
    localparam int unsigned BIT_STRT = 7;
    localparam int unsigned BIT_STOP = 6;
    localparam int unsigned BIT_DONE = 5;
    localparam int unsigned BIT_DIE  = 4;
    localparam int unsigned BIT_OVF  = 3;
    localparam int unsigned BIT_OIE  = 2;
    localparam int unsigned BIT_ERR  = 1;
    localparam int unsigned BIT_POUT = 0;

    typedef struct packed {
        logic run_hi;
        logic run_lo;
        logic done;
        logic done_ie;
        logic ovf;
        logic ovf_ie;
        logic err;
        logic pout;
    } pwt_csr_t;

endpackage

// File: rtl/pwt_sync_edge.sv
module pwt_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    localparam int unsigned MSB = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= pin;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], pin};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= chain_q[MSB];
        end
    end

    assign rise = chain_q[MSB] & ~last_q;
    assign fall = ~chain_q[MSB] & last_q;

endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
    import pwt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_cmd,
    input  logic stop_cmd,
    input  logic tick,
    input  logic rise,
    input  logic fall,
    output logic running,
    output logic restart,
    output logic arm,
    output logic cnt_en,
    output logic latch
);

    pwt_state_e state_q;
    pwt_state_e state_d;
    logic       cmd_any;

    assign cmd_any = start_cmd | stop_cmd;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: T_STOP beats T_START, both beat the edge transitions
    always_comb begin
        state_d = state_q;
        if (stop_cmd) begin
            state_d = ST_IDLE;                       // T_STOP
        end else if (start_cmd) begin
            state_d = ST_ARMED;                      // T_START
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_ARMED:   if (rise) state_d = ST_MEASURE;  // T_BEGIN
                ST_MEASURE: if (fall) state_d = ST_IDLE;     // T_DONE
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        running = 1'b0;
        restart = start_cmd & ~stop_cmd;
        arm     = 1'b0;
        cnt_en  = 1'b0;
        latch   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                running = 1'b0;
            end
            ST_ARMED: begin
                running = 1'b1;
                arm     = rise & ~cmd_any;
            end
            ST_MEASURE: begin
                running = 1'b1;
                latch   = fall & ~cmd_any;
                cnt_en  = tick & ~fall & ~cmd_any;
            end
            default: begin
                running = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pwt_counter.sv
module pwt_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    localparam logic [W-1:0] CNT_TOP = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt  = cnt_q;
    assign wrap = en & (cnt_q == CNT_TOP);

endmodule

// File: rtl/pwt_result.sv
module pwt_result #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch,
    input  logic [W-1:0] cnt,
    input  logic         rd,
    output logic [W-1:0] result,
    output logic         err
);

    logic [W-1:0] res_q;
    logic         full_q;
    logic         err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            full_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (latch) begin
                res_q <= cnt;
            end
            if (latch) begin
                full_q <= 1'b1;
            end else if (rd) begin
                full_q <= 1'b0;
            end
            if (latch && full_q) begin
                err_q <= 1'b1;
            end else if (rd) begin
                err_q <= 1'b0;
            end
        end
    end

    assign result = res_q;
    assign err    = err_q;

endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer
    import pwt_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             pulse_in,
    input  logic             tick,
    input  logic             res_rd,
    output logic [CNT_W-1:0] result,
    output logic             irq_done,
    output logic             irq_ovf,
    output logic             pulse_out
);

    logic             start_cmd;
    logic             stop_cmd;
    logic             p_rise;
    logic             p_fall;
    logic             running;
    logic             restart;
    logic             arm;
    logic             cnt_en;
    logic             res_latch;
    logic             cnt_wrap;
    logic [CNT_W-1:0] cnt_val;
    logic             err_flag;
    logic             done_q;
    logic             done_ie_q;
    logic             ovf_q;
    logic             ovf_ie_q;
    logic             pout_q;
    logic             unused_wbits;
    pwt_csr_t         csr;

    assign start_cmd    = reg_wr & reg_wdata[BIT_STRT];
    assign stop_cmd     = reg_wr & reg_wdata[BIT_STOP];
    assign unused_wbits = ^{reg_wdata[BIT_DONE], reg_wdata[BIT_ERR], reg_wdata[BIT_POUT]};

    pwt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pulse_in),
        .rise (p_rise),
        .fall (p_fall)
    );

    pwt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_cmd(start_cmd),
        .stop_cmd (stop_cmd),
        .tick     (tick),
        .rise     (p_rise),
        .fall     (p_fall),
        .running  (running),
        .restart  (restart),
        .arm      (arm),
        .cnt_en   (cnt_en),
        .latch    (res_latch)
    );

    pwt_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart | arm),
        .en   (cnt_en),
        .cnt  (cnt_val),
        .wrap (cnt_wrap)
    );

    pwt_result #(.W(CNT_W)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .latch (res_latch),
        .cnt   (cnt_val),
        .rd    (res_rd),
        .result(result),
        .err   (err_flag)
    );

    // Flags and enables; hardware sets win over software clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            done_ie_q <= 1'b0;
            ovf_q     <= 1'b0;
            ovf_ie_q  <= 1'b0;
            pout_q    <= 1'b0;
        end else begin
            if (reg_wr) begin
                done_ie_q <= reg_wdata[BIT_DIE];
                ovf_ie_q  <= reg_wdata[BIT_OIE];
            end
            if (res_latch) begin
                done_q <= 1'b1;
            end else if (restart) begin
                done_q <= 1'b0;
            end
            if (cnt_wrap) begin
                ovf_q <= 1'b1;
            end else if (reg_wr && !reg_wdata[BIT_OVF]) begin
                ovf_q <= 1'b0;
            end
            if (cnt_wrap) begin
                pout_q <= ~pout_q;
            end
        end
    end

    always_comb begin
        csr.run_hi  = running;
        csr.run_lo  = running;
        csr.done    = done_q;
        csr.done_ie = done_ie_q;
        csr.ovf     = ovf_q;
        csr.ovf_ie  = ovf_ie_q;
        csr.err     = err_flag;
        csr.pout    = pout_q;
    end

    assign reg_rdata = csr;
    assign irq_done  = done_q & done_ie_q;
    assign irq_ovf   = ovf_q & ovf_ie_q;
    assign pulse_out = pout_q;

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       irq_done,
    input logic       irq_ovf,
    input logic       pulse_out,
    input logic       wrap,
    input logic       latch
);

    p_run_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] == reg_rdata[6]);

    p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[7] && !reg_wdata[6]) |=> (reg_rdata[7:6] == 2'b11 && !reg_rdata[5]));

    p_stop_idles_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[6]) |=> (reg_rdata[7:6] == 2'b00));

    p_done_on_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (reg_rdata[5] && reg_rdata[7:6] == 2'b00));

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> reg_rdata[3]);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[3] && !(reg_wr && !reg_wdata[3])) |=> reg_rdata[3]);

    p_pout_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (pulse_out != $past(pulse_out)));

    p_pout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(pulse_out));

    p_irq_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (reg_rdata[5] && reg_rdata[4]));

    p_irq_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> (reg_rdata[3] && reg_rdata[2]));

    p_err_on_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[1]) |-> $past(latch));

endmodule

bind pulse_width_timer pwt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_done (irq_done),
    .irq_ovf  (irq_ovf),
    .pulse_out(pulse_out),
    .wrap     (cnt_wrap),
    .latch    (res_latch)
);

// File: tb/tb_pulse_width_timer.sv
module tb_pulse_width_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic        pulse_in = 1'b0;
    logic        tick = 1'b0;
    logic        res_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] result;
    logic        irq_done;
    logic        irq_ovf;
    logic        pulse_out;

    always #10 clk = ~clk;

    pulse_width_timer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pulse_in (pulse_in),
        .tick     (tick),
        .res_rd   (res_rd),
        .result   (result),
        .irq_done (irq_done),
        .irq_ovf  (irq_ovf),
        .pulse_out(pulse_out)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Behavioural reference: 0 idle, 1 armed, 2 measuring
    int m_st = 0, m_cnt = 0, m_res = 0;
    int m_full = 0, m_err = 0, m_done = 0, m_die = 0, m_ovf = 0, m_oie = 0, m_pout = 0;
    int m_s1 = 0, m_s2 = 0, m_s2d = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_res = 0; m_full = 0; m_err = 0; m_done = 0;
            m_die = 0; m_ovf = 0; m_oie = 0; m_pout = 0; m_s1 = 0; m_s2 = 0; m_s2d = 0;
        end else begin
            bit rise, fall, go, halt, wrapped, cap;
            rise = (m_s2 == 1) && (m_s2d == 0);
            fall = (m_s2 == 0) && (m_s2d == 1);
            go = reg_wr && reg_wdata[7];
            halt = reg_wr && reg_wdata[6];
            wrapped = 0;
            cap = 0;
            if (halt) m_st = 0;
            else if (go) begin m_st = 1; m_cnt = 0; m_done = 0; end
            else if (m_st == 1 && rise) begin m_st = 2; m_cnt = 0; end
            else if (m_st == 2 && fall) begin cap = 1; m_st = 0; m_done = 1; end
            else if (m_st == 2 && tick) begin
                if (m_cnt == 65535) begin wrapped = 1; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            if (reg_wr) begin m_die = reg_wdata[4]; m_oie = reg_wdata[2]; end
            if (wrapped) m_ovf = 1;
            else if (reg_wr && !reg_wdata[3]) m_ovf = 0;
            if (wrapped) m_pout = 1 - m_pout;
            if (cap && m_full == 1) m_err = 1;
            else if (res_rd) m_err = 0;
            if (cap) m_full = 1;
            else if (res_rd) m_full = 0;
            if (cap) m_res = m_cnt;
            m_s2d = m_s2; m_s2 = m_s1; m_s1 = pulse_in;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            bit rs;
            rs = !rst_n;
            chk(rs ? "R1" : "R2 R3", "run code", reg_rdata[7:6], (m_st != 0) ? 3 : 0);
            chk(rs ? "R1" : "R5", "done flag", reg_rdata[5], m_done);
            chk(rs ? "R1" : "R10", "enables", {reg_rdata[4], reg_rdata[2]}, m_die * 2 + m_oie);
            chk(rs ? "R1" : "R6", "ovf flag", reg_rdata[3], m_ovf);
            chk(rs ? "R1" : "R9", "err flag", reg_rdata[1], m_err);
            chk(rs ? "R1" : "R7", "pout bit", reg_rdata[0], m_pout);
            chk(rs ? "R1" : "R7", "pulse_out", pulse_out, m_pout);
            chk(rs ? "R1" : "R4 R11", "result", result, m_res);
            chk(rs ? "R1" : "R8", "irq_done", irq_done, m_done & m_die);
            chk(rs ? "R1" : "R8", "irq_ovf", irq_ovf, m_ovf & m_oie);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic consume();
        @(negedge clk);
        res_rd = 1'b1;
        @(negedge clk);
        res_rd = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired before the scenarios ended");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);                         // R1 checked while reset is held
        rst_n = 1'b1;
        idle(2);
        wr(8'h00);                       // R2: zero command bits do nothing
        idle(2);
        wr(8'h37);                       // R10: only the enables take the written value
        idle(2);
        pulse_in = 1'b1; idle(5);        // R11: pulse while idle is ignored
        pulse_in = 1'b0; idle(5);
        wr(8'h94);                       // R2: start with both enables
        tick = 1'b1; idle(4);            // R11: ticks while armed do not count
        pulse_in = 1'b1;                 // R4: measured pulse with sparse ticks
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            tick = (i % 2 == 0);
        end
        pulse_in = 1'b0; idle(6);
        tick = 1'b0; idle(2);            // R5 R8: done flag and interrupt
        wr(8'h94);                       // R9: second result while unread
        tick = 1'b1; pulse_in = 1'b1; idle(7);
        pulse_in = 1'b0; idle(6);
        tick = 1'b0;
        consume(); idle(2);              // R9: read clears the error
        wr(8'h94);                       // R2: restart in the middle of a pulse
        tick = 1'b1; pulse_in = 1'b1; idle(8);
        wr(8'h94); idle(4);
        pulse_in = 1'b0; idle(3);
        pulse_in = 1'b1; idle(5);
        pulse_in = 1'b0; idle(6);
        wr(8'h94);                       // R3: stop in the middle of a pulse
        pulse_in = 1'b1; idle(6);
        wr(8'h54); idle(3);
        pulse_in = 1'b0; idle(4);
        wr(8'hD4); idle(3);              // R3: stop wins over start
        consume(); idle(2);
        wr(8'h94);                       // R6 R7: first wrap
        pulse_in = 1'b1;
        idle(65545);
        pulse_in = 1'b0; idle(6);
        tick = 1'b0;
        wr(8'h1C); idle(2);              // R6: writing one keeps the flag
        wr(8'h14); idle(2);              // R6: writing zero clears it
        wr(8'h94);                       // R6 R7: wrap meets a clearing write
        tick = 1'b1; pulse_in = 1'b1;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            if (m_st == 2 && m_cnt == 65535) begin
                reg_wr = 1'b1;
                reg_wdata = 8'h14;
                @(negedge clk);
                reg_wr = 1'b0;
                break;
            end
        end
        idle(10);
        pulse_in = 1'b0; idle(6);
        tick = 1'b0;
        wr(8'h10); idle(3);              // R8: overflow interrupt masked
        finished = 1;
        summary();
        $finish;
    end

endmodule